// File: doc/BRIEF.md
# SPI Flash Single-Byte Command Sequencer

This block is a master-side sequencer for a serial NOR flash on a four-wire SPI bus. A client presents one request that carries a read/write flag, a 24-bit byte address and, for a write, one data byte. The block then runs a complete frame on the bus under a single chip-select assertion. The frame is a fixed opcode byte, the address split into three bytes, and a final data byte. The final byte is either driven out (write) or sampled from the flash (read). Whatever the flash returns while the command and address are going out is thrown away.

The serial clock is derived from the system clock by an even divisor. Mode 0 timing is used: the clock rests low, outgoing bits change on the falling edge and incoming bits are taken on the rising edge. A busy flag covers the frame and a short recovery window after it, and any request made while busy is dropped. When chip select is released, a single-cycle done pulse marks the end of the frame. For reads, the captured byte is presented on the same cycle.

Top module: `spi_flash_seq`

## Requirements
- R1: Each accepted request produces exactly one chip-select low period (spi_cs_n falls once, rises once) that contains exactly 40 rising edges of spi_sclk with no deassertion in between.
- R2: The first 8 bits of a frame are the opcode: 0x03 for a read (req_write=0) and 0x02 for a write (req_write=1), sent MSB first.
- R3: Bits 9 to 32 of the frame carry req_addr as three bytes, high byte [23:16] first, then [15:8], then [7:0], each byte MSB first.
- R4: For a write, bits 33 to 40 carry req_wdata MSB first.
- R5: For a read, spi_miso sampled at rising edges 33 to 40 forms rd_data, with the first sampled bit as bit 7.
- R6: The values of spi_miso at rising edges 1 to 32 have no effect on rd_data.
- R7: Mode 0: spi_sclk is low whenever spi_cs_n is high, and spi_mosi does not change while spi_sclk is high.
- R8: Within a frame, every high and every low phase of spi_sclk lasts CLK_DIV/2 system clocks. The same holds from the spi_cs_n fall to the first rising edge and from the last falling edge to the spi_cs_n rise.
- R9: done is high for exactly one cycle per frame, in the first cycle in which spi_cs_n is high again. After a read, rd_data holds the read byte. A write leaves rd_data unchanged.
- R10: busy is high in the cycle after a request is accepted and stays high until the block is idle again. A req_valid seen while busy starts no frame and changes no field of the running frame.
- R11: Between the rise of spi_cs_n and the next fall, spi_cs_n stays high for at least CLK_DIV system clocks.
- R12: After reset: spi_cs_n=1, spi_sclk=0, busy=0, done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_write | input | 1 | 1 = write one byte, 0 = read one byte |
| req_addr | input | 24 | Flash byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Frame or recovery window in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 8 | Byte returned by the last read |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with CLK_DIV=6. This gives a half period of three system clocks, so the divider counter passes through a middle value and wraps, which a divisor of 2 would never do. The three-cycle phases also leave room to see a spi_mosi change that lands while spi_sclk is high. The default opcodes and three address bytes are kept, so every frame is 40 bits long. With CLK_DIV=6 one frame plus its recovery window is about 250 clocks, which allows several dozen random frames, back-to-back requests issued on the first idle cycle, and requests poked in mid-frame.

// File: rtl/spi_flash_seq_pkg.sv
package spi_flash_seq_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  // opcode byte + address bytes + one data byte
  function automatic int unsigned frame_len(input int unsigned addr_bytes);
    return BYTE_W * (addr_bytes + 2);
  endfunction

  // index (0-based) of the first rising edge that belongs to the data byte
  function automatic int unsigned data_start(input int unsigned addr_bytes);
    return BYTE_W * (addr_bytes + 1);
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned HALF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(HALF) + 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

  // a half period never ends before the counter starts from zero
  p_tick_after_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && HALF > 1) |-> $past(en));

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int unsigned FRAME_BITS = 40,
  parameter int unsigned RX_W       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  advance,
  input  logic                  sample,
  input  logic                  keep,
  input  logic                  miso,
  output logic                  mosi,
  output logic [RX_W-1:0]       rx_byte
);
  logic [FRAME_BITS-1:0] sr_q;
  logic [RX_W-1:0]       rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_word;
    end else if (advance) begin
      sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (load) begin
      rx_q <= '0;
    end else if (sample && keep) begin
      rx_q <= {rx_q[RX_W-2:0], miso};
    end
  end

  assign mosi    = sr_q[FRAME_BITS-1];
  assign rx_byte = rx_q;

  // command-phase samples never reach the receive register
  p_rx_ignores_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !keep && !load) |=> $stable(rx_byte));

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_flash_seq_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 40,
  parameter int unsigned DATA_START = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic tick,
  output logic tick_en,
  output logic busy,
  output logic cs_n,
  output logic sclk,
  output logic load,
  output logic advance,
  output logic sample,
  output logic keep,
  output logic frame_end,
  output logic is_read
);
  localparam int unsigned RW = $clog2(FRAME_BITS + 1);
  localparam logic [RW-1:0] LAST_RISE = RW'(FRAME_BITS);
  localparam logic [RW-1:0] KEEP_FROM = RW'(DATA_START);

  seq_state_e    state_q;
  logic [RW-1:0] rise_cnt_q;
  logic          sclk_q;
  logic          cs_q;
  logic          rd_q;
  logic          gap_ph_q;

  logic start;
  logic rise_evt;
  logic fall_evt;

  always_comb begin
    start     = (state_q == ST_IDLE) && req_valid;
    rise_evt  = (state_q == ST_SHIFT) && tick && !sclk_q;
    fall_evt  = (state_q == ST_SHIFT) && tick && sclk_q;
    load      = start;
    advance   = fall_evt && (rise_cnt_q != LAST_RISE);
    sample    = rise_evt;
    keep      = rise_cnt_q >= KEEP_FROM;
    frame_end = (state_q == ST_TAIL) && tick;
    tick_en   = state_q != ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rise_cnt_q <= '0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      rd_q       <= 1'b0;
      gap_ph_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_SHIFT;
            cs_q       <= 1'b0;
            rise_cnt_q <= '0;
            rd_q       <= !req_write;
          end
        end
        ST_SHIFT: begin
          if (rise_evt) begin
            sclk_q     <= 1'b1;
            rise_cnt_q <= rise_cnt_q + 1'b1;
          end else if (fall_evt) begin
            sclk_q <= 1'b0;
            if (rise_cnt_q == LAST_RISE) state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state_q  <= ST_GAP;
            cs_q     <= 1'b1;
            gap_ph_q <= 1'b0;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_ph_q) state_q <= ST_IDLE;
            else          gap_ph_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = state_q != ST_IDLE;
  assign cs_n    = cs_q;
  assign sclk    = sclk_q;
  assign is_read = rd_q;

  p_forty_rises_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> rise_cnt_q == LAST_RISE);

  p_no_rise_past_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> rise_cnt_q < LAST_RISE);

  p_clock_parks_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> !sclk_q);

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_flash_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned ADDR_BYTES = 3,
  parameter logic [7:0]  OP_READ    = 8'h03,
  parameter logic [7:0]  OP_WRITE   = 8'h02
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [8*ADDR_BYTES-1:0]   req_addr,
  input  logic [7:0]                req_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [7:0]                rd_data,
  output logic                      spi_sclk,
  output logic                      spi_cs_n,
  output logic                      spi_mosi,
  input  logic                      spi_miso
);
  localparam int unsigned ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int unsigned FRAME_BITS = frame_len(ADDR_BYTES);
  localparam int unsigned DATA_START = data_start(ADDR_BYTES);
  localparam int unsigned HALF       = CLK_DIV / 2;

  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] a,
    input logic [7:0]        d
  );
    return {wr ? OP_WRITE : OP_READ, a, wr ? d : 8'h00};
  endfunction

  logic tick, tick_en;
  logic load, advance, sample, keep, frame_end, is_read;
  logic [7:0] rx_byte;
  logic done_q;
  logic [7:0] rd_q;

  spi_half_tick #(.HALF(HALF)) u_tick (
    .clk (clk), .rst_n (rst_n), .en (tick_en), .tick (tick)
  );

  spi_frame_ctl #(.FRAME_BITS(FRAME_BITS), .DATA_START(DATA_START)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tick      (tick),
    .tick_en   (tick_en),
    .busy      (busy),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .load      (load),
    .advance   (advance),
    .sample    (sample),
    .keep      (keep),
    .frame_end (frame_end),
    .is_read   (is_read)
  );

  spi_bit_shifter #(.FRAME_BITS(FRAME_BITS), .RX_W(8)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (pack_frame(req_write, req_addr, req_wdata)),
    .advance   (advance),
    .sample    (sample),
    .keep      (keep),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= frame_end;
      if (frame_end && is_read) rd_q <= rx_byte;
    end
  end

  assign done    = done_q;
  assign rd_data = rd_q;

  // cycles spent with chip select high, saturating
  localparam int unsigned HW = $clog2(CLK_DIV + 1) + 1;
  localparam logic [HW-1:0] GAP_MIN = HW'(CLK_DIV);
  logic [HW-1:0] cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cs_hi_cnt <= GAP_MIN;
    else if (!spi_cs_n)      cs_hi_cnt <= '0;
    else if (cs_hi_cnt != GAP_MIN) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  p_cs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> cs_hi_cnt >= GAP_MIN);

  p_sclk_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_sclk_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_sclk) || $fell(spi_sclk)) |-> $past(tick));

  p_done_with_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !$past(spi_cs_n)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !$past(busy));

  initial begin
    a_even_div_r8: assert (CLK_DIV >= 2 && CLK_DIV % 2 == 0)
      else $error("CLK_DIV must be even and at least 2");
  end

endmodule

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;
  localparam int unsigned CLK_DIV = 6;
  localparam int unsigned HALF    = CLK_DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic busy, done, spi_sclk, spi_cs_n, spi_mosi;
  logic [7:0] rd_data;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_flash_seq #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- bench flash model / bus monitor ----------------
  logic [7:0]  flash_byte = '0;
  bit          garbage_ones = 0;
  logic        prv_sclk = 0, prv_cs = 1, prv_mosi = 0;
  int          rises = 0, run = 0, cs_hi_run = 1000, last_gap = 1000;
  logic [39:0] bits = '0, last_bits = '0;
  int          last_rises = 0, frames = 0, done_total = 0;
  int          viol_run = 0, viol_mosi = 0, viol_idle = 0;
  bit          done_at_rise = 0;

  function automatic logic garbage();
    return garbage_ones ? 1'b1 : 1'($urandom());
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (done) done_total++;
      if (spi_cs_n && spi_sclk) viol_idle++;
      if (!spi_cs_n && prv_cs) begin
        last_gap = cs_hi_run;
        rises = 0; bits = '0; run = 1;
        spi_miso = garbage();
      end else if (!spi_cs_n) begin
        if (spi_sclk != prv_sclk) begin
          if (run != HALF) viol_run++;
          run = 1;
          if (spi_sclk) begin
            rises++;
            bits = {bits[38:0], spi_mosi};
          end else if (rises >= 32 && rises < 40) begin
            spi_miso = flash_byte[7 - (rises - 32)];
          end else begin
            spi_miso = garbage();
          end
        end else begin
          run++;
          if (spi_sclk && prv_sclk && spi_mosi != prv_mosi) viol_mosi++;
        end
      end
      if (spi_cs_n && !prv_cs) begin
        if (run != HALF) viol_run++;
        frames++;
        last_rises = rises;
        last_bits = bits;
        done_at_rise = done;
      end
      cs_hi_run = spi_cs_n ? cs_hi_run + 1 : 0;
      prv_sclk = spi_sclk; prv_cs = spi_cs_n; prv_mosi = spi_mosi;
    end
  end

  // ---------------- expected values ----------------
  function automatic logic [31:0] exp_header(input bit wr, input logic [23:0] a);
    logic [7:0] op = wr ? 8'h02 : 8'h03;
    return {op, a[23:16], a[15:8], a[7:0]};
  endfunction

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input bit wr, input logic [23:0] a, input logic [7:0] d,
                           input logic [7:0] fb, input bit poke, input string tag);
    int f0 = frames;
    int d0 = done_total;
    int vr = viol_run, vm = viol_mosi, vi = viol_idle;
    logic [7:0] prev_rd = rd_data;
    logic [31:0] hdr;
    flash_byte = fb;
    while (busy) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R10", {tag, " busy after accept"}, busy, 1);
    if (poke) begin
      wait_cycles(7);
      req_valid = 1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
      req_valid = 0;
    end
    while (frames == f0) @(negedge clk);
    while (busy) @(negedge clk);
    wait_cycles(2 * CLK_DIV);
    chk(frames == f0 + 1 && spi_cs_n, "R10", {tag, " one frame per request"}, frames - f0, 1);
    chk(last_rises == 40, "R1", {tag, " rising edges in frame"}, last_rises, 40);
    hdr = exp_header(wr, a);
    chk(last_bits[39:32] == hdr[31:24], "R2", {tag, " opcode"}, last_bits[39:32], hdr[31:24]);
    chk(last_bits[31:8] == hdr[23:0], "R3", {tag, " address"}, last_bits[31:8], hdr[23:0]);
    if (wr) begin
      chk(last_bits[7:0] == d, "R4", {tag, " write byte"}, last_bits[7:0], d);
      chk(rd_data == prev_rd, "R9", {tag, " rd_data kept on write"}, rd_data, prev_rd);
    end else begin
      chk(rd_data == fb, "R5", {tag, " read byte"}, rd_data, fb);
    end
    chk(done_total - d0 == 1 && done_at_rise, "R9", {tag, " done pulse"}, done_total - d0, 1);
    chk(viol_mosi == vm && viol_idle == vi, "R7", {tag, " mode 0"}, viol_mosi - vm + viol_idle - vi, 0);
    chk(viol_run == vr, "R8", {tag, " sclk phase length"}, viol_run - vr, 0);
    chk(last_gap >= CLK_DIV, "R11", {tag, " cs high gap"}, last_gap, CLK_DIV);
  endtask

  // back-to-back: next request on the first idle cycle
  task automatic back_to_back();
    int f0 = frames;
    flash_byte = 8'h5A;
    req_valid = 1; req_write = 0; req_addr = 24'h000100; req_wdata = 0;
    @(negedge clk);
    req_valid = 0;
    while (frames == f0) @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 24'hABCDEF; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 0;
    while (frames == f0 + 1) @(negedge clk);
    chk(last_gap >= CLK_DIV, "R11", "back-to-back cs gap", last_gap, CLK_DIV);
    chk(last_bits[31:8] == 24'hABCDEF, "R3", "back-to-back address", last_bits[31:8], 24'hABCDEF);
    chk(rd_data == 8'h5A, "R9", "back-to-back rd_data kept", rd_data, 8'h5A);
    while (busy) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    wait_cycles(3);
    chk(spi_cs_n == 1 && spi_sclk == 0 && busy == 0 && done == 0, "R12", "reset state",
        {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
    rst_n = 1;
    wait_cycles(2);
    chk(spi_cs_n == 1 && spi_sclk == 0 && busy == 0 && done == 0, "R12", "idle after reset",
        {spi_cs_n, spi_sclk, busy, done}, 4'b1000);

    // directed corners
    run_frame(0, 24'hFFFFFF, 8'h00, 8'hFF, 0, "read all-ones");
    run_frame(1, 24'h000000, 8'hA5, 8'h00, 0, "write zero addr");
    run_frame(1, 24'h800001, 8'h81, 8'h00, 1, "write poked");
    run_frame(0, 24'h123456, 8'h00, 8'hC3, 1, "read poked");
    garbage_ones = 1;
    run_frame(0, 24'h0F0F0F, 8'h00, 8'h00, 0, "R6 ones during command");
    chk(rd_data == 8'h00, "R6", "command-phase miso ignored", rd_data, 8'h00);
    garbage_ones = 0;
    back_to_back();

    // random mix
    for (int i = 0; i < 30; i++) begin
      run_frame(1'($urandom()), 24'($urandom()), 8'($urandom()), 8'($urandom()),
                ($urandom() % 4) == 0, "random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule